// File: doc/BRIEF.md
# Execution Unit Sleep/Wake Controller

This block decides, cycle by cycle, whether each gated execution unit of a five-stage in-order pipeline (IF, ID, EX, MEM, WB) is powered down, powering up or usable. There are five units: ALU, shifter, multiplier, divider and coprocessor-0. The controller sees the unit-usage vector of the instruction in fetch, so it can start waking a unit two stages before the unit is needed. For each unit it drives a sleep line and a ready flag. It raises a pipeline hold when the instruction in EX needs a unit that is still waking.

When units go back to sleep depends on one of four run-time strategies. A unit can sleep after every use. It can sleep only on first-level cache misses. It can sleep only on second-level misses. Or it can sleep on second-level misses and also when a compiler hint is set. Sleep pays off only if the idle period is longer than the unit's break-even time. For this reason each unit counts its sleep cycles in a saturating counter, and on wake it flags a sleep that was shorter than its programmed break-even threshold.

Top module: `exu_pg_ctrl`

## Requirements
- R1: After reset, every unit is asleep (sleep_o bit 1, ready_o bit 0), stall_o is 0, all short-sleep flags are 0 and the active strategy is 00.
- R2: A valid fetch instruction whose usage bit is set makes a sleeping unit leave sleep at the next edge. The unit's ready_o rises L cycles after the request cycle, where L = wake_lat_i, and 0 is treated as 1. Unit bits: 0 ALU, 1 shifter, 2 multiplier, 3 divider, 4 coprocessor-0.
- R3: With L of 2 or less, back-to-back instructions on sleeping units never raise stall_o.
- R4: Strategy 00: a unit used by the instruction leaving EX goes to sleep at that edge, unless a valid instruction in IF or ID also uses it.
- R5: Strategy 01: an l1_miss_i pulse puts every awake unit that is not in use to sleep. l2_miss_i has no effect, and units stay awake after use.
- R6: Strategy 10: l2_miss_i puts idle awake units to sleep. l1_miss_i has no effect.
- R7: Strategy 11: l2_miss_i, or an instruction carrying the hint leaving EX, puts idle awake units to sleep.
- R8: When a sleep event and a wake request for the same unit fall in the same cycle, the request wins and the unit stays awake.
- R9: stall_o is 1 while the EX instruction uses a unit that is not ready. During a stall the fetch instruction is not accepted and the EX instruction is held.
- R10: strategy_i is loaded only at an edge where EX holds no instruction. Otherwise the previous strategy stays active.
- R11: Each unit counts its sleep cycles in a saturating CNT_W-bit counter. On wake, short_sleep_o is set to (cycles asleep, saturated) < the unit's threshold in bet_i, and it holds until the next wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| if_valid_i | input | 1 | Valid instruction in fetch |
| if_use_i | input | N_UNITS | Units the fetch instruction will use |
| if_hint_i | input | 1 | Compiler sleep hint of the fetch instruction |
| l1_miss_i | input | 1 | First-level cache miss pulse |
| l2_miss_i | input | 1 | Second-level cache miss pulse |
| strategy_i | input | 2 | Requested sleep strategy (00 every use, 01 L1, 10 L2, 11 hint+L2) |
| wake_lat_i | input | LAT_W | Wake-up latency in cycles |
| bet_i | input | N_UNITS*CNT_W | Per-unit break-even thresholds, unit u at bits u*CNT_W |
| sleep_o | output | N_UNITS | Unit is powered down |
| ready_o | output | N_UNITS | Unit is powered and usable |
| short_sleep_o | output | N_UNITS | Last sleep was shorter than the threshold |
| stall_o | output | 1 | Hold the pipeline |

## Verification
Two events can fall on the same unit in the same cycle. One is a sleep trigger: the end of use under strategy 00, a miss pulse, or a hinted instruction leaving EX. The other is a wake request from a fetch instruction that uses the same unit. A directed case places a second user of a unit in fetch exactly when the first leaves EX, and checks that the unit remains ready. The random phase pulses misses on top of a dense instruction stream to produce many such collisions. Every output is compared each cycle with a bench model in which the request always wins.

// File: rtl/exu_pg_pkg.sv
package exu_pg_pkg;
  typedef enum logic [1:0] {
    STRAT_EVERY   = 2'b00,
    STRAT_L1      = 2'b01,
    STRAT_L2      = 2'b10,
    STRAT_HINT_L2 = 2'b11
  } strat_e;

  typedef enum logic [1:0] {
    U_SLEEP  = 2'b00,
    U_WAKING = 2'b01,
    U_AWAKE  = 2'b10
  } ustate_e;
endpackage

// File: rtl/exu_pg_pipe.sv
module exu_pg_pipe #(
  parameter int N_UNITS = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               if_valid_i,
  input  logic [N_UNITS-1:0] if_use_i,
  input  logic               if_hint_i,
  input  logic               advance_i,
  output logic               id_valid_o,
  output logic [N_UNITS-1:0] id_use_o,
  output logic               ex_valid_o,
  output logic [N_UNITS-1:0] ex_use_o,
  output logic               ex_hint_o
);
  logic id_hint_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_valid_o <= 1'b0;
      id_use_o   <= '0;
      id_hint_q  <= 1'b0;
      ex_valid_o <= 1'b0;
      ex_use_o   <= '0;
      ex_hint_o  <= 1'b0;
    end else if (advance_i) begin
      id_valid_o <= if_valid_i;
      id_use_o   <= if_valid_i ? if_use_i : '0;
      id_hint_q  <= if_valid_i & if_hint_i;
      ex_valid_o <= id_valid_o;
      ex_use_o   <= id_use_o;
      ex_hint_o  <= id_hint_q;
    end
  end

  assert_hold_ex_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!advance_i) |=> ($stable(ex_use_o) && $stable(ex_valid_o)));
endmodule

// File: rtl/exu_pg_policy.sv
module exu_pg_policy
  import exu_pg_pkg::*;
#(
  parameter int N_UNITS = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         strategy_i,
  input  logic               l1_miss_i,
  input  logic               l2_miss_i,
  input  logic [N_UNITS-1:0] wake_req_i,
  input  logic               id_valid_i,
  input  logic [N_UNITS-1:0] id_use_i,
  input  logic               ex_valid_i,
  input  logic [N_UNITS-1:0] ex_use_i,
  input  logic               ex_hint_i,
  input  logic               stall_i,
  output logic [N_UNITS-1:0] sleep_evt_o,
  output logic [N_UNITS-1:0] in_use_o
);
  strat_e strat_q;
  logic   done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          strat_q <= STRAT_EVERY;
    else if (!ex_valid_i) strat_q <= strat_e'(strategy_i);
  end

  assign done = ex_valid_i & ~stall_i;

  always_comb begin
    in_use_o = wake_req_i
             | (id_valid_i ? id_use_i : '0)
             | ((ex_valid_i & stall_i) ? ex_use_i : '0);
    unique case (strat_q)
      STRAT_EVERY:   sleep_evt_o = done ? ex_use_i : '0;
      STRAT_L1:      sleep_evt_o = {N_UNITS{l1_miss_i}};
      STRAT_L2:      sleep_evt_o = {N_UNITS{l2_miss_i}};
      STRAT_HINT_L2: sleep_evt_o = {N_UNITS{l2_miss_i | (done & ex_hint_i)}};
      default:       sleep_evt_o = '0;
    endcase
  end

  assert_strat_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_valid_i |=> $stable(strat_q));
endmodule

// File: rtl/exu_pg_unit.sv
module exu_pg_unit
  import exu_pg_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int LAT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wake_req_i,
  input  logic             sleep_evt_i,
  input  logic             in_use_i,
  input  logic [LAT_W-1:0] wake_lat_i,
  input  logic [CNT_W-1:0] bet_i,
  output logic             sleep_o,
  output logic             ready_o,
  output logic             short_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [LAT_W-1:0] LAT_ONE = LAT_W'(1);

  ustate_e          state_q;
  logic [LAT_W-1:0] wcnt_q;
  logic [CNT_W-1:0] scnt_q;
  logic [CNT_W-1:0] scnt_inc;

  assign scnt_inc = (scnt_q == CNT_MAX) ? scnt_q : scnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= U_SLEEP;
      wcnt_q  <= '0;
      scnt_q  <= '0;
      short_o <= 1'b0;
    end else begin
      unique case (state_q)
        U_SLEEP: begin
          if (wake_req_i) begin
            short_o <= (scnt_inc < bet_i);
            if (wake_lat_i <= LAT_ONE) begin
              state_q <= U_AWAKE;
            end else begin
              state_q <= U_WAKING;
              wcnt_q  <= wake_lat_i - LAT_ONE;
            end
          end else begin
            scnt_q <= scnt_inc;
          end
        end
        U_WAKING: begin
          if (wcnt_q <= LAT_ONE) state_q <= U_AWAKE;
          else                   wcnt_q  <= wcnt_q - LAT_ONE;
        end
        U_AWAKE: begin
          if (sleep_evt_i && !in_use_i) begin
            state_q <= U_SLEEP;
            scnt_q  <= '0;
          end
        end
        default: state_q <= U_SLEEP;
      endcase
    end
  end

  assign sleep_o = (state_q == U_SLEEP);
  assign ready_o = (state_q == U_AWAKE);

  assert_wake_leaves_sleep_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_o && wake_req_i) |=> !sleep_o);
  assert_ready_no_rewake_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> (ready_o || sleep_o));
  assert_busy_stays_up_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_o && in_use_i) |=> !sleep_o);
  assert_cnt_saturates_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_o && !wake_req_i && scnt_q == CNT_MAX) |=> (scnt_q == CNT_MAX));
endmodule

// File: rtl/exu_pg_ctrl.sv
module exu_pg_ctrl #(
  parameter int N_UNITS = 5,
  parameter int CNT_W   = 8,
  parameter int LAT_W   = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       if_valid_i,
  input  logic [N_UNITS-1:0]         if_use_i,
  input  logic                       if_hint_i,
  input  logic                       l1_miss_i,
  input  logic                       l2_miss_i,
  input  logic [1:0]                 strategy_i,
  input  logic [LAT_W-1:0]           wake_lat_i,
  input  logic [N_UNITS*CNT_W-1:0]   bet_i,
  output logic [N_UNITS-1:0]         sleep_o,
  output logic [N_UNITS-1:0]         ready_o,
  output logic [N_UNITS-1:0]         short_sleep_o,
  output logic                       stall_o
);
  logic [N_UNITS-1:0] wake_req, id_use, ex_use, sleep_evt, in_use;
  logic               id_valid, ex_valid, ex_hint;

  assign wake_req = if_valid_i ? if_use_i : '0;
  assign stall_o  = ex_valid & |(ex_use & ~ready_o);

  exu_pg_pipe #(.N_UNITS(N_UNITS)) u_pipe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .if_valid_i (if_valid_i),
    .if_use_i   (if_use_i),
    .if_hint_i  (if_hint_i),
    .advance_i  (~stall_o),
    .id_valid_o (id_valid),
    .id_use_o   (id_use),
    .ex_valid_o (ex_valid),
    .ex_use_o   (ex_use),
    .ex_hint_o  (ex_hint)
  );

  exu_pg_policy #(.N_UNITS(N_UNITS)) u_policy (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strategy_i  (strategy_i),
    .l1_miss_i   (l1_miss_i),
    .l2_miss_i   (l2_miss_i),
    .wake_req_i  (wake_req),
    .id_valid_i  (id_valid),
    .id_use_i    (id_use),
    .ex_valid_i  (ex_valid),
    .ex_use_i    (ex_use),
    .ex_hint_i   (ex_hint),
    .stall_i     (stall_o),
    .sleep_evt_o (sleep_evt),
    .in_use_o    (in_use)
  );

  for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
    exu_pg_unit #(.CNT_W(CNT_W), .LAT_W(LAT_W)) u_unit (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wake_req_i  (wake_req[g]),
      .sleep_evt_i (sleep_evt[g]),
      .in_use_i    (in_use[g]),
      .wake_lat_i  (wake_lat_i),
      .bet_i       (bet_i[g*CNT_W +: CNT_W]),
      .sleep_o     (sleep_o[g]),
      .ready_o     (ready_o[g]),
      .short_o     (short_sleep_o[g])
    );
  end

  assert_stall_unit_pending_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (ex_valid && (ex_use & ~ready_o) != '0 && sleep_o != '1));
endmodule

// File: tb/exu_pg_ctrl_test.sv
module exu_pg_ctrl_test;
  localparam int N = 5;
  localparam int CW = 8;
  localparam int LW = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          if_valid_i = 1'b0;
  logic [N-1:0]  if_use_i = '0;
  logic          if_hint_i = 1'b0;
  logic          l1_miss_i = 1'b0;
  logic          l2_miss_i = 1'b0;
  logic [1:0]    strategy_i = 2'b00;
  logic [LW-1:0] wake_lat_i = 3'd1;
  logic [N*CW-1:0] bet_i = '0;
  logic [N-1:0]  sleep_o, ready_o, short_sleep_o;
  logic          stall_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  // bench model state: 0 sleep, 1 waking, 2 awake
  int   ms[N];
  int   mw[N];
  int   mc[N];
  bit   msh[N];
  bit   idv, exv, idh, exh;
  logic [N-1:0] idu, exu;
  int   mstrat;

  exu_pg_ctrl #(.N_UNITS(N), .CNT_W(CW), .LAT_W(LW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .if_valid_i(if_valid_i), .if_use_i(if_use_i),
    .if_hint_i(if_hint_i), .l1_miss_i(l1_miss_i), .l2_miss_i(l2_miss_i),
    .strategy_i(strategy_i), .wake_lat_i(wake_lat_i), .bet_i(bet_i),
    .sleep_o(sleep_o), .ready_o(ready_o), .short_sleep_o(short_sleep_o), .stall_o(stall_o)
  );

  always #4 clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] m_ready();
    logic [N-1:0] r;
    for (int u = 0; u < N; u++) r[u] = (ms[u] == 2);
    return r;
  endfunction

  function automatic logic m_stall();
    return exv && ((exu & ~m_ready()) != '0);
  endfunction

  task automatic model_reset();
    for (int u = 0; u < N; u++) begin ms[u] = 0; mw[u] = 0; mc[u] = 0; msh[u] = 0; end
    idv = 0; exv = 0; idh = 0; exh = 0; idu = '0; exu = '0; mstrat = 0;
  endtask

  task automatic model_step();
    logic st, done, req, inuse, evt;
    int inc, lat, bet;
    st = m_stall();
    done = exv && !st;
    lat = int'(wake_lat_i);
    for (int u = 0; u < N; u++) begin
      req = if_valid_i && if_use_i[u];
      inuse = req || (idv && idu[u]) || (exv && exu[u] && st);
      case (mstrat)
        0: evt = done && exu[u];
        1: evt = l1_miss_i;
        2: evt = l2_miss_i;
        default: evt = l2_miss_i || (done && exh);
      endcase
      bet = int'(bet_i[u*CW +: CW]);
      inc = (mc[u] >= 255) ? 255 : mc[u] + 1;
      case (ms[u])
        0: if (req) begin
             msh[u] = (inc < bet);
             if (lat <= 1) ms[u] = 2; else begin ms[u] = 1; mw[u] = lat - 1; end
           end else mc[u] = inc;
        1: if (mw[u] <= 1) ms[u] = 2; else mw[u] = mw[u] - 1;
        default: if (evt && !inuse) begin ms[u] = 0; mc[u] = 0; end
      endcase
    end
    if (!exv) mstrat = int'(strategy_i);
    if (!st) begin
      exv = idv; exu = idu; exh = idh;
      idv = if_valid_i; idu = if_valid_i ? if_use_i : '0; idh = if_valid_i && if_hint_i;
    end
  endtask

  task automatic compare_all();
    logic [N-1:0] es, esh;
    for (int u = 0; u < N; u++) begin es[u] = (ms[u] == 0); esh[u] = msh[u]; end
    chk("R4 sleep_o vs model", 32'(sleep_o), 32'(es));
    chk("R2 ready_o vs model", 32'(ready_o), 32'(m_ready()));
    chk("R9 stall_o vs model", 32'(stall_o), 32'(m_stall()));
    chk("R11 short_sleep_o vs model", 32'(short_sleep_o), 32'(esh));
  endtask

  task automatic step(input logic v, input logic [N-1:0] u, input logic h,
                      input logic l1, input logic l2, input logic [1:0] st);
    if_valid_i = v; if_use_i = u; if_hint_i = h;
    l1_miss_i = l1; l2_miss_i = l2; strategy_i = st;
    model_step();
    @(negedge clk_i);
    compare_all();
  endtask

  task automatic idle(input int n, input logic [1:0] st);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0, 1'b0, st);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic v, h;
    logic [N-1:0] u;
    void'($urandom(32'd20240611));
    model_reset();
    for (int k = 0; k < N; k++) bet_i[k*CW +: CW] = 8'd6;
    bet_i[4*CW +: CW] = 8'd255;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1 sleep after reset", 32'(sleep_o), 32'h1f);
    chk("R1 ready after reset", 32'(ready_o), 32'h0);
    chk("R1 stall after reset", 32'(stall_o), 32'h0);
    chk("R1 short after reset", 32'(short_sleep_o), 32'h0);

    // R11 saturation: cp0 asleep > 255 cycles, threshold 255
    wake_lat_i = 3'd1;
    idle(300, 2'b00);
    step(1'b1, 5'b10000, 1'b0, 1'b0, 1'b0, 2'b00);
    chk("R11 saturated count not short", 32'(short_sleep_o[4]), 32'h0);
    chk("R2 latency 1 ready next cycle", 32'(ready_o[4]), 32'h1);
    idle(2, 2'b00);
    chk("R4 cp0 sleeps after use", 32'(sleep_o[4]), 32'h1);
    idle(2, 2'b00);
    step(1'b1, 5'b10000, 1'b0, 1'b0, 1'b0, 2'b00);
    chk("R11 brief sleep flagged short", 32'(short_sleep_o[4]), 32'h1);
    idle(4, 2'b00);

    // R2 and R9: latency 3 forces one stall cycle on the ALU
    wake_lat_i = 3'd3;
    step(1'b1, 5'b00001, 1'b0, 1'b0, 1'b0, 2'b00);
    chk("R2 waking not asleep", 32'(sleep_o[0]), 32'h0);
    chk("R2 waking not ready", 32'(ready_o[0]), 32'h0);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, 2'b00);
    chk("R9 stall while waking", 32'(stall_o), 32'h1);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, 2'b00);
    chk("R2 ready after 3 cycles", 32'(ready_o[0]), 32'h1);
    chk("R9 stall released", 32'(stall_o), 32'h0);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, 2'b00);
    chk("R4 ALU sleeps after EX", 32'(sleep_o[0]), 32'h1);
    idle(3, 2'b00);

    // R8 wake request collides with end-of-use sleep
    wake_lat_i = 3'd1;
    step(1'b1, 5'b00010, 1'b0, 1'b0, 1'b0, 2'b00);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, 2'b00);
    step(1'b1, 5'b00010, 1'b0, 1'b0, 1'b0, 2'b00);
    chk("R8 request wins over sleep", 32'(sleep_o[1]), 32'h0);
    chk("R8 shifter stays ready", 32'(ready_o[1]), 32'h1);
    idle(5, 2'b00);

    // R3 latency 2, back-to-back multiplier use
    wake_lat_i = 3'd2;
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 5'b00100, 1'b0, 1'b0, 1'b0, 2'b00);
      chk("R3 no stall with latency 2", 32'(stall_o), 32'h0);
    end
    idle(4, 2'b00);
    chk("R3 no stall while draining", 32'(stall_o), 32'h0);

    // R10 strategy request ignored while EX occupied
    wake_lat_i = 3'd1;
    step(1'b1, 5'b00001, 1'b0, 1'b0, 1'b0, 2'b00);
    step(1'b1, 5'b00001, 1'b0, 1'b0, 1'b0, 2'b00);
    for (int i = 0; i < 4; i++) step(1'b1, 5'b00001, 1'b0, 1'b0, 1'b0, 2'b01);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, 2'b01);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, 2'b01);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, 2'b00);
    chk("R10 strategy 00 kept, ALU asleep", 32'(sleep_o[0]), 32'h1);
    idle(4, 2'b00);

    // R5 strategy 01
    idle(2, 2'b01);
    step(1'b1, 5'b01000, 1'b0, 1'b0, 1'b0, 2'b01);
    idle(3, 2'b01);
    chk("R5 divider stays awake after use", 32'(ready_o[3]), 32'h1);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, 2'b01);
    chk("R5 L2 miss ignored", 32'(ready_o[3]), 32'h1);
    step(1'b0, '0, 1'b0, 1'b1, 1'b0, 2'b01);
    chk("R5 L1 miss sleeps divider", 32'(sleep_o[3]), 32'h1);

    // R6 strategy 10
    idle(2, 2'b10);
    step(1'b1, 5'b01000, 1'b0, 1'b0, 1'b0, 2'b10);
    idle(3, 2'b10);
    step(1'b0, '0, 1'b0, 1'b1, 1'b0, 2'b10);
    chk("R6 L1 miss ignored", 32'(ready_o[3]), 32'h1);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, 2'b10);
    chk("R6 L2 miss sleeps divider", 32'(sleep_o[3]), 32'h1);

    // R7 strategy 11 hint
    idle(2, 2'b11);
    step(1'b1, 5'b01000, 1'b1, 1'b0, 1'b0, 2'b11);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, 2'b11);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, 2'b11);
    chk("R7 hint sleeps divider after EX", 32'(sleep_o[3]), 32'h1);
    step(1'b1, 5'b01000, 1'b0, 1'b0, 1'b0, 2'b11);
    idle(3, 2'b11);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, 2'b11);
    chk("R7 L2 miss sleeps divider", 32'(sleep_o[3]), 32'h1);

    // random phase, latency 0..4
    v = 1'b0; u = '0; h = 1'b0;
    for (int p = 0; p < 5; p++) begin
      wake_lat_i = LW'(p);
      for (int k = 0; k < N; k++) bet_i[k*CW +: CW] = CW'($urandom_range(2, 40));
      for (int i = 0; i < 700; i++) begin
        logic [1:0] st;
        if (!m_stall()) begin
          v = ($urandom_range(0, 9) < 7);
          u = N'(1) << $urandom_range(0, N - 1);
          if ($urandom_range(0, 3) == 0) u = u | (N'(1) << $urandom_range(0, N - 1));
          if ($urandom_range(0, 9) == 0) u = '0;
          h = ($urandom_range(0, 7) == 0);
        end
        st = ($urandom_range(0, 15) == 0) ? 2'($urandom_range(0, 3)) : strategy_i;
        step(v, u, h, ($urandom_range(0, 9) == 0), ($urandom_range(0, 29) == 0), st);
      end
    end
    finish_run();
  end
endmodule